// File: doc/BRIEF.md
# Symmetric Pre-Add FIR Filter (8 taps)

This block filters a stream of signed Q1.15 samples with an eight-tap FIR whose impulse response is mirror-symmetric. It does not use one multiplier per tap. Each pair of delay-line taps that share a weight is summed first, and that sum is then multiplied once. Four multipliers therefore do the work of eight. The four weights arrive on live input ports, so they can change between samples without any load sequence.

Each cycle with `in_valid` high accepts one sample. The filter result is computed only from the samples already stored, never from the sample being accepted. It appears one cycle later, together with the oldest stored sample and an `out_valid` pulse. When `in_valid` is low, the delay line and both data outputs hold their values.

Top module: `sym_fir8`

## Requirements
- R1: While `rst_n` is low, and after its release, every delay register and both data outputs read zero and `out_valid` is low.
- R2: An accepted sample enters tap 1. Each older tap k takes the value of tap k-1. The value leaving tap 8 is discarded.
- R3: With tap k holding the sample accepted k samples before the current one, the full-precision result is Σ c_j·(tap_j + tap_(9-j)) for j = 1..4. Weight c_j is coefficient-bus slice bits [16j-1 : 16j-16], so c_1 weights the outer pair (taps 1 and 8) and c_4 weights the inner pair (taps 4 and 5).
- R4: The result registered on an accepted sample uses the taps as they were before that sample was shifted in. An impulse therefore shows up at `y_out` starting with the next accepted sample.
- R5: The full-precision sum is rounded to Q1.15 by adding 2^14 and shifting right arithmetically by 15. A tie of exactly one half rounds toward plus infinity.
- R6: A rounded value above 32767 gives 32767, and one below -32768 gives -32768.
- R7: `out_valid` is high exactly in the cycle after an accepted sample. `y_out` and `oldest_out` update in that same cycle.
- R8: While `in_valid` is low, `in_sample` is ignored, the delay line holds, and `y_out` and `oldest_out` keep their values.
- R9: `oldest_out` shows tap 8 as it was before the accepted sample's shift. Until eight samples have been accepted since reset, that value is zero.
- R10: Weights are sampled on the accepting clock edge. A change of weights affects the very next result, and all-zero weights give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Accept `in_sample` on this edge |
| in_sample | input | 16 | Signed Q1.15 input sample |
| coef_bus | input | 64 | Four signed Q1.15 weights, slice j-1 (bits 16j-1:16j-16) is c_j, outer pair first |
| out_valid | output | 1 | Result registered from the previous cycle's accept |
| y_out | output | 16 | Rounded, saturated Q1.15 filter result |
| oldest_out | output | 16 | Tap 8 contents before the accepting shift |

## Verification
The bound checker covers the cycle-level contracts on every clock: `out_valid` tracking the previous cycle's `in_valid`, outputs frozen while no sample is accepted, zero weights giving a zero result, and `oldest_out` staying zero before the delay line has filled. The arithmetic can only be shown by the bench's scenarios against a bit-accurate model. That covers the mirrored pairing and weight order (impulse response), rounding ties, saturation at both rails, weights changed mid-stream, and the rule that the accepted sample itself does not reach its own result.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;
  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_COEF_W = 16;
  localparam int unsigned DEF_TAPS   = 8;
  localparam int unsigned DEF_FRAC   = 15;

  // Bits an adder tree of n equal-width leaves adds to its leaf width.
  function automatic int unsigned tree_growth(input int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/sym_fir_taps.sv
module sym_fir_taps #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAPS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [DATA_W-1:0]        din,
  output logic [TAPS*DATA_W-1:0]   taps_flat
);
  logic [DATA_W-1:0] tap_q [TAPS];
  logic [DATA_W-1:0] tap_d [TAPS];

  // Next state: first stage takes the new sample, the rest take their neighbour.
  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      tap_d[k] = tap_q[k];
    end
    if (shift_en) begin
      tap_d[0] = din;
      for (int k = 1; k < TAPS; k++) begin
        tap_d[k] = tap_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        tap_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < TAPS; k++) begin
        tap_q[k] <= tap_d[k];
      end
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_flat
    assign taps_flat[g*DATA_W +: DATA_W] = tap_q[g];
  end
endmodule

// File: rtl/sym_fir_preadd.sv
module sym_fir_preadd #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NPAIR  = 4,
  localparam int unsigned TAPS  = 2 * NPAIR,
  localparam int unsigned PRE_W = DATA_W + 1
) (
  input  logic [TAPS*DATA_W-1:0]  taps_flat,
  output logic [NPAIR*PRE_W-1:0]  pair_flat
);
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic signed [DATA_W-1:0] near_tap;
    logic signed [DATA_W-1:0] far_tap;
    logic signed [PRE_W-1:0]  pair_sum;
    assign near_tap = $signed(taps_flat[g*DATA_W +: DATA_W]);
    assign far_tap  = $signed(taps_flat[(TAPS-1-g)*DATA_W +: DATA_W]);
    assign pair_sum = PRE_W'(near_tap) + PRE_W'(far_tap);
    assign pair_flat[g*PRE_W +: PRE_W] = pair_sum;
  end
endmodule

// File: rtl/sym_fir_mac_tree.sv
module sym_fir_mac_tree #(
  parameter int unsigned PRE_W  = 17,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned NPAIR  = 4,
  localparam int unsigned PROD_W = PRE_W + COEF_W,
  localparam int unsigned SUM_W  = PROD_W + sym_fir_pkg::tree_growth(NPAIR)
) (
  input  logic [NPAIR*PRE_W-1:0]   pair_flat,
  input  logic [NPAIR*COEF_W-1:0]  coef_flat,
  output logic [SUM_W-1:0]         acc
);
  localparam int unsigned NODES = 2 * NPAIR - 1;

  // Heap-ordered tree: node 0 is the root, leaves start at NPAIR-1.
  logic signed [SUM_W-1:0] node [NODES];

  for (genvar g = 0; g < NPAIR; g++) begin : g_mul
    logic signed [PRE_W-1:0]  pre;
    logic signed [COEF_W-1:0] wgt;
    logic signed [PROD_W-1:0] prod;
    assign pre  = $signed(pair_flat[g*PRE_W +: PRE_W]);
    assign wgt  = $signed(coef_flat[g*COEF_W +: COEF_W]);
    assign prod = PROD_W'(pre) * PROD_W'(wgt);
    assign node[NPAIR-1+g] = SUM_W'(prod);
  end

  for (genvar j = 0; j < NPAIR - 1; j++) begin : g_add
    assign node[j] = node[2*j+1] + node[2*j+2];
  end

  assign acc = node[0];
endmodule

// File: rtl/sym_fir_round_sat.sv
module sym_fir_round_sat #(
  parameter int unsigned IN_W  = 35,
  parameter int unsigned FRAC  = 15,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]   acc,
  output logic [OUT_W-1:0]  y
);
  localparam int unsigned W = IN_W + 1;
  localparam logic signed [W-1:0] HALF = $signed(W'(1) << (FRAC - 1));
  localparam logic signed [W-1:0] MAXV = $signed((W'(1) << (OUT_W - 1)) - W'(1));
  localparam logic signed [W-1:0] MINV = -MAXV - $signed(W'(1));

  logic signed [W-1:0] ext;
  logic signed [W-1:0] biased;
  logic signed [W-1:0] scaled;

  always_comb begin
    ext    = W'($signed(acc));
    biased = ext + HALF;
    scaled = biased >>> FRAC;
    if (scaled > MAXV) begin
      y = MAXV[OUT_W-1:0];
    end else if (scaled < MINV) begin
      y = MINV[OUT_W-1:0];
    end else begin
      y = scaled[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/sym_fir8.sv
module sym_fir8 #(
  parameter int unsigned DATA_W = sym_fir_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = sym_fir_pkg::DEF_COEF_W,
  parameter int unsigned TAPS   = sym_fir_pkg::DEF_TAPS,
  parameter int unsigned FRAC   = sym_fir_pkg::DEF_FRAC,
  localparam int unsigned NPAIR = TAPS / 2,
  localparam int unsigned PRE_W = DATA_W + 1,
  localparam int unsigned SUM_W = PRE_W + COEF_W + sym_fir_pkg::tree_growth(NPAIR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_sample,
  input  logic [NPAIR*COEF_W-1:0]  coef_bus,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        y_out,
  output logic [DATA_W-1:0]        oldest_out
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  logic [TAPS*DATA_W-1:0]  taps_flat;
  logic [NPAIR*PRE_W-1:0]  pair_flat;
  logic [SUM_W-1:0]        acc;
  logic [DATA_W-1:0]       y_rounded;

  sym_fir_taps #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .shift_en  (in_valid),
    .din       (in_sample),
    .taps_flat (taps_flat)
  );

  sym_fir_preadd #(.DATA_W(DATA_W), .NPAIR(NPAIR)) u_preadd (
    .taps_flat (taps_flat),
    .pair_flat (pair_flat)
  );

  sym_fir_mac_tree #(.PRE_W(PRE_W), .COEF_W(COEF_W), .NPAIR(NPAIR)) u_mac (
    .pair_flat (pair_flat),
    .coef_flat (coef_bus),
    .acc       (acc)
  );

  sym_fir_round_sat #(.IN_W(SUM_W), .FRAC(FRAC), .OUT_W(DATA_W)) u_rsat (
    .acc (acc),
    .y   (y_rounded)
  );

  // Output stage: next-state and register split, enable written out.
  logic              valid_d;
  logic [DATA_W-1:0] y_d;
  logic [DATA_W-1:0] oldest_d;

  always_comb begin
    valid_d  = in_valid;
    y_d      = y_out;
    oldest_d = oldest_out;
    if (in_valid) begin
      y_d      = y_rounded;
      oldest_d = taps_flat[(TAPS-1)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid  <= 1'b0;
      y_out      <= '0;
      oldest_out <= '0;
    end else begin
      out_valid  <= valid_d;
      y_out      <= y_d;
      oldest_out <= oldest_d;
    end
  end
endmodule

// File: rtl/sym_fir8_chk.sv
module sym_fir8_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [(TAPS/2)*COEF_W-1:0]    coef_bus,
  input logic                          out_valid,
  input logic [DATA_W-1:0]             y_out,
  input logic [DATA_W-1:0]             oldest_out
);
  localparam int unsigned CNT_W = $clog2(TAPS + 1);
  logic [CNT_W-1:0] fill_cnt;
  logic             filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (in_valid && !filled) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end
  assign filled = (fill_cnt == CNT_W'(TAPS));

  // R7
  valid_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7
  valid_low_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y_out) && $stable(oldest_out)));

  // R10
  zero_weights_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && coef_bus == '0) |=> (y_out == '0));

  // R9
  oldest_unfilled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !filled) |=> (oldest_out == '0));
endmodule

bind sym_fir8 sym_fir8_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .coef_bus   (coef_bus),
  .out_valid  (out_valid),
  .y_out      (y_out),
  .oldest_out (oldest_out)
);

// File: tb/sym_fir8_test.sv
module sym_fir8_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_sample;
  logic [63:0] coef_bus;
  logic        out_valid;
  logic [15:0] y_out;
  logic [15:0] oldest_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int c [4];
  int hist [8];
  int last_y = 0;
  int last_old = 0;

  always #5 clk = ~clk;

  sym_fir8 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_bus(coef_bus), .out_valid(out_valid), .y_out(y_out), .oldest_out(oldest_out)
  );

  function automatic int ref_y();
    longint acc = 0;
    longint r;
    for (int j = 0; j < 4; j++) acc += longint'(c[j]) * (longint'(hist[j]) + longint'(hist[7-j]));
    r = (acc + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_coefs(input int a, input int b, input int d, input int e);
    c[0] = a; c[1] = b; c[2] = d; c[3] = e;
  endtask

  task automatic send(input int x, input string req);
    int ey;
    int eo;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 16'(x);
    coef_bus  = {16'(c[3]), 16'(c[2]), 16'(c[1]), 16'(c[0])};
    ey = ref_y();
    eo = hist[7];
    @(posedge clk);
    #2;
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "y_out", int'($signed(y_out)), ey);
    check(req, "oldest_out", int'($signed(oldest_out)), eo);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'($signed(16'(x)));
    last_y = ey;
    last_old = eo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 16'($urandom);
      @(posedge clk);
      #2;
      check("R7", "out_valid idle", int'(out_valid), 0);
      check("R8", "y_out held", int'($signed(y_out)), last_y);
      check("R8", "oldest_out held", int'($signed(oldest_out)), last_old);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 8; i++) send(0, "R2");
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 8; k++) hist[k] = 0;
    set_coefs(-4388, -2746, 6639, 13317);
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; coef_bus = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid reset", int'(out_valid), 0);
    check("R1", "y_out reset", int'(y_out), 0);
    check("R1", "oldest_out reset", int'(oldest_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "y_out after release", int'(y_out), 0);

    // R3 R4: impulse, weights appear outer-to-inner then mirrored
    send(32767, "R4");
    check("R4", "impulse not in own result", last_y, 0);
    for (int i = 0; i < 9; i++) send(0, "R3");
    // R9: impulse left tap 8 on the ninth accept
    idle(3);

    // R3: step response
    for (int i = 0; i < 12; i++) send(16384, "R3");
    idle(2);

    // R10: weights changed between samples
    set_coefs(1000, -2000, 3000, -4000);
    for (int i = 0; i < 4; i++) send(int'($signed(16'($urandom))), "R10");
    set_coefs(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) send(int'($signed(16'($urandom))), "R10");

    // R5: exact ties
    set_coefs(16384, 0, 0, 0);
    flush();
    send(1, "R5");
    send(0, "R5");
    check("R5", "+0.5 tie", last_y, 1);
    set_coefs(-16384, 0, 0, 0);
    flush();
    send(1, "R5");
    send(0, "R5");
    check("R5", "-0.5 tie", last_y, 0);

    // R6: both rails
    set_coefs(32767, 32767, 32767, 32767);
    for (int i = 0; i < 9; i++) send(32767, "R6");
    check("R6", "upper rail", last_y, 32767);
    for (int i = 0; i < 9; i++) send(-32768, "R6");
    check("R6", "lower rail", last_y, -32768);

    // R2 R8: random stream with gaps and changing weights
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0)
        set_coefs(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                  int'($signed(16'($urandom))), int'($signed(16'($urandom))));
      if ($urandom_range(3) == 0) idle(1);
      send(int'($signed(16'($urandom))), "R2");
    end
    idle(2);
    finish_run();
  end
endmodule